// File: doc/BRIEF.md
# Single-Bit Boolean Processor

This block performs the one-bit operations of a small controller's bit-manipulation path. It keeps a one-bit carry accumulator (CY) and takes three things: an operation code, the value of one bit read from a bit-addressable location, and a flag from the address decoder saying that this bit is a guarded status flag. For each operation it produces the next CY, a write-back value and write strobe for the addressed bit, and a branch decision for the bit-test jumps.

The surrounding logic turns a bit address into a byte and bit position and holds the memory; neither is part of this block. Every output comes from a register. The result of an operation presented before a rising edge is therefore visible after that edge. A write strobe or a branch decision lasts one cycle. The operation code is decoded into a small control word. A combinational unit evaluates that word against the operand and CY, and the top level registers the results and applies write protection.

There is no multi-cycle sequence, so the block has no state machine. Its only named state is the CY register. Every operation completes in one transition, from the current CY to the next CY.

Top module: `bitproc_unit`

## Requirements
- R1: While `rst` is high at a rising edge, `cy_o`, `bit_we_o`, `bit_wd_o` and `take_o` become 0.
- R2: Operation codes 1, 2 and 3 clear, set and invert CY in turn. They leave `bit_we_o` at 0.
- R3: Operation codes 4, 5 and 6 write 0, write 1 and write the inverse of `bit_i` to the addressed bit, with `bit_we_o` at 1. CY is unchanged.
- R4: Code 7 sets CY to CY AND `bit_i`, and code 9 sets CY to CY OR `bit_i`. Neither writes the bit.
- R5: Code 8 sets CY to CY AND NOT `bit_i`, and code 10 sets CY to CY OR NOT `bit_i`. The stored bit is not written.
- R6: Code 11 copies `bit_i` into CY without a bit write. Code 12 writes CY to the bit and leaves CY unchanged.
- R7: Code 13 asserts `take_o` when `bit_i` is 1, and code 14 asserts it when `bit_i` is 0. Neither changes CY or writes the bit.
- R8: Code 15 with `bit_i` at 1 asserts `take_o` and writes 0 to the bit in the same cycle. With `bit_i` at 0 it does neither.
- R9: When `prot_i` is 1, `bit_we_o` stays 0 for every operation. CY and `take_o` behave exactly as they do when `prot_i` is 0.
- R10: Code 0 (idle) keeps CY and leaves `bit_we_o` and `take_o` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| op_i | input | 4 | Operation code |
| bit_i | input | 1 | Value of the addressed bit |
| prot_i | input | 1 | Addressed bit is a guarded status flag |
| cy_o | output | 1 | Carry accumulator |
| bit_we_o | output | 1 | Write strobe for the addressed bit |
| bit_wd_o | output | 1 | Value to write to the addressed bit |
| take_o | output | 1 | Branch decision |

## Verification
The test-and-clear operation raises the branch decision and the bit write-back in the same cycle. When the target is a guarded flag, write protection acts in that same cycle as well. The bench issues code 15 with the bit set and with the bit clear, and repeats both with `prot_i` high. It expects the jump in both set cases and the write of 0 only when the bit is not guarded. CY must stay unchanged through all four cases.

// File: rtl/bitproc_pkg.sv
package bitproc_pkg;

    localparam int OP_W = 4;

    typedef enum logic [OP_W-1:0] {
        OP_IDLE   = 4'd0,
        OP_CY_CLR = 4'd1,
        OP_CY_SET = 4'd2,
        OP_CY_INV = 4'd3,
        OP_B_CLR  = 4'd4,
        OP_B_SET  = 4'd5,
        OP_B_INV  = 4'd6,
        OP_AND    = 4'd7,
        OP_ANDN   = 4'd8,
        OP_OR     = 4'd9,
        OP_ORN    = 4'd10,
        OP_LD_CY  = 4'd11,
        OP_ST_CY  = 4'd12,
        OP_J_SET  = 4'd13,
        OP_J_CLR  = 4'd14,
        OP_J_TCLR = 4'd15
    } op_e;

    typedef enum logic [2:0] {
        CYF_KEEP, CYF_ZERO, CYF_ONE, CYF_INV, CYF_AND, CYF_OR, CYF_LOAD
    } cy_fn_e;

    typedef enum logic [2:0] {
        BF_NONE, BF_ZERO, BF_ONE, BF_INV, BF_FROM_CY, BF_CLR_IF_SET
    } bit_fn_e;

    typedef enum logic [1:0] {
        TST_NONE, TST_SET, TST_CLR
    } test_e;

    typedef struct packed {
        cy_fn_e  cy_fn;
        logic    inv_opnd;
        bit_fn_e bit_fn;
        test_e   test;
    } ctrl_t;

endpackage

// File: rtl/bitproc_decode.sv
module bitproc_decode
    import bitproc_pkg::*;
(
    input  op_e   op,
    output ctrl_t ctrl
);
    always_comb begin
        ctrl = '{cy_fn: CYF_KEEP, inv_opnd: 1'b0, bit_fn: BF_NONE, test: TST_NONE};
        unique case (op)
            OP_IDLE:   ;
            OP_CY_CLR: ctrl.cy_fn = CYF_ZERO;
            OP_CY_SET: ctrl.cy_fn = CYF_ONE;
            OP_CY_INV: ctrl.cy_fn = CYF_INV;
            OP_B_CLR:  ctrl.bit_fn = BF_ZERO;
            OP_B_SET:  ctrl.bit_fn = BF_ONE;
            OP_B_INV:  ctrl.bit_fn = BF_INV;
            OP_AND:    ctrl.cy_fn = CYF_AND;
            OP_ANDN:   begin ctrl.cy_fn = CYF_AND; ctrl.inv_opnd = 1'b1; end
            OP_OR:     ctrl.cy_fn = CYF_OR;
            OP_ORN:    begin ctrl.cy_fn = CYF_OR;  ctrl.inv_opnd = 1'b1; end
            OP_LD_CY:  ctrl.cy_fn = CYF_LOAD;
            OP_ST_CY:  ctrl.bit_fn = BF_FROM_CY;
            OP_J_SET:  ctrl.test = TST_SET;
            OP_J_CLR:  ctrl.test = TST_CLR;
            OP_J_TCLR: begin ctrl.test = TST_SET; ctrl.bit_fn = BF_CLR_IF_SET; end
            default:   ;
        endcase
    end
endmodule

// File: rtl/bitproc_alu.sv
module bitproc_alu
    import bitproc_pkg::*;
(
    input  ctrl_t ctrl,
    input  logic  bit_val,
    input  logic  cy_cur,
    output logic  cy_nxt,
    output logic  wr_req,
    output logic  wr_val,
    output logic  take
);
    logic opnd;

    always_comb begin
        opnd = bit_val ^ ctrl.inv_opnd;

        unique case (ctrl.cy_fn)
            CYF_KEEP: cy_nxt = cy_cur;
            CYF_ZERO: cy_nxt = 1'b0;
            CYF_ONE:  cy_nxt = 1'b1;
            CYF_INV:  cy_nxt = ~cy_cur;
            CYF_AND:  cy_nxt = cy_cur & opnd;
            CYF_OR:   cy_nxt = cy_cur | opnd;
            CYF_LOAD: cy_nxt = bit_val;
            default:  cy_nxt = cy_cur;
        endcase

        wr_req = 1'b0;
        wr_val = 1'b0;
        unique case (ctrl.bit_fn)
            BF_NONE:       ;
            BF_ZERO:       wr_req = 1'b1;
            BF_ONE:        begin wr_req = 1'b1; wr_val = 1'b1; end
            BF_INV:        begin wr_req = 1'b1; wr_val = ~bit_val; end
            BF_FROM_CY:    begin wr_req = 1'b1; wr_val = cy_cur; end
            BF_CLR_IF_SET: wr_req = bit_val;
            default:       ;
        endcase

        unique case (ctrl.test)
            TST_NONE: take = 1'b0;
            TST_SET:  take = bit_val;
            TST_CLR:  take = ~bit_val;
            default:  take = 1'b0;
        endcase
    end
endmodule

// File: rtl/bitproc_unit.sv
module bitproc_unit
    import bitproc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [3:0] op_i,
    input  logic       bit_i,
    input  logic       prot_i,
    output logic       cy_o,
    output logic       bit_we_o,
    output logic       bit_wd_o,
    output logic       take_o
);
    ctrl_t ctrl;
    logic  cy_nxt, wr_req, wr_val, take_nxt;

    bitproc_decode u_dec (.op(op_e'(op_i)), .ctrl(ctrl));

    bitproc_alu u_alu (
        .ctrl(ctrl), .bit_val(bit_i), .cy_cur(cy_o),
        .cy_nxt(cy_nxt), .wr_req(wr_req), .wr_val(wr_val), .take(take_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cy_o     <= 1'b0;
            bit_we_o <= 1'b0;
            bit_wd_o <= 1'b0;
            take_o   <= 1'b0;
        end else begin
            cy_o     <= cy_nxt;
            bit_we_o <= wr_req & ~prot_i;
            bit_wd_o <= wr_val;
            take_o   <= take_nxt;
        end
    end

    // R9
    guarded_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        bit_we_o |-> !$past(prot_i));

    // R2
    cy_only_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        (op_i inside {4'd1, 4'd2, 4'd3, 4'd7, 4'd8, 4'd9, 4'd10, 4'd11}) |=> !bit_we_o);

    // R8
    tclr_write_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (op_i == 4'd15 && bit_i && !prot_i) |=> (take_o && bit_we_o && !bit_wd_o));

    // R7
    take_from_test_chk: assert property (@(posedge clk) disable iff (rst)
        (op_i inside {4'd0, 4'd1, 4'd2, 4'd3, 4'd4, 4'd5, 4'd6, 4'd7,
                      4'd8, 4'd9, 4'd10, 4'd11, 4'd12}) |=> !take_o);

    // R3
    bit_ops_keep_cy_chk: assert property (@(posedge clk) disable iff (rst)
        (op_i inside {4'd4, 4'd5, 4'd6, 4'd12, 4'd13, 4'd14, 4'd15}) |=> $stable(cy_o));

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (op_i == 4'd0) |=> (!bit_we_o && !take_o && $stable(cy_o)));

endmodule

// File: tb/sim_bitproc_unit.sv
`timescale 1ns/1ps
module sim_bitproc_unit;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [3:0] op = 4'd0;
    logic bv = 1'b0, pr = 1'b0;
    logic cy, we, wd, tk;

    typedef struct {
        logic cy; logic we; logic wd; logic tk; string req;
    } exp_t;
    exp_t q[$];

    int checks = 0, errors = 0;
    logic m_cy = 1'b0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    bitproc_unit u0 (.clk(clk), .rst(rst), .op_i(op), .bit_i(bv), .prot_i(pr),
                     .cy_o(cy), .bit_we_o(we), .bit_wd_o(wd), .take_o(tk));

    task automatic issue(input logic [3:0] o, input logic b, input logic p, input string req);
        exp_t e;
        logic nc, w, v, t;
        @(negedge clk);
        op = o; bv = b; pr = p;
        nc = m_cy; w = 1'b0; v = 1'b0; t = 1'b0;
        case (o)
            4'd1:  nc = 1'b0;
            4'd2:  nc = 1'b1;
            4'd3:  nc = ~m_cy;
            4'd4:  w = 1'b1;
            4'd5:  begin w = 1'b1; v = 1'b1; end
            4'd6:  begin w = 1'b1; v = ~b; end
            4'd7:  nc = m_cy & b;
            4'd8:  nc = m_cy & ~b;
            4'd9:  nc = m_cy | b;
            4'd10: nc = m_cy | ~b;
            4'd11: nc = b;
            4'd12: begin w = 1'b1; v = m_cy; end
            4'd13: t = b;
            4'd14: t = ~b;
            4'd15: begin t = b; w = b; end
            default: ;
        endcase
        e.cy = nc; e.we = w & ~p; e.wd = v; e.tk = t; e.req = req;
        m_cy = nc;
        q.push_back(e);
    endtask

    always @(posedge clk) begin
        #1;
        if (!rst && q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (cy !== e.cy || we !== e.we || tk !== e.tk || (e.we && wd !== e.wd)) begin
                errors++;
                $display("FAIL %s: got cy=%b we=%b wd=%b take=%b exp cy=%b we=%b wd=%b take=%b",
                         e.req, cy, we, wd, tk, e.cy, e.we, e.wd, e.tk);
            end
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (cy !== 1'b0 || we !== 1'b0 || tk !== 1'b0) begin
            errors++;
            $display("FAIL R1: got cy=%b we=%b take=%b exp 0 0 0", cy, we, tk);
        end
        rst = 1'b0;
        // R2
        issue(4'd2, 1'b0, 1'b0, "R2");
        issue(4'd3, 1'b1, 1'b0, "R2");
        issue(4'd3, 1'b0, 1'b0, "R2");
        issue(4'd1, 1'b1, 1'b0, "R2");
        // R3
        issue(4'd5, 1'b0, 1'b0, "R3");
        issue(4'd4, 1'b1, 1'b0, "R3");
        issue(4'd6, 1'b1, 1'b0, "R3");
        issue(4'd6, 1'b0, 1'b0, "R3");
        // R4 / R5 over all operand and carry combinations
        for (int c = 0; c < 2; c++)
            for (int b = 0; b < 2; b++)
                for (int k = 7; k <= 10; k++) begin
                    issue(c[0] ? 4'd2 : 4'd1, 1'b0, 1'b0, "R2");
                    issue(k[3:0], b[0], 1'b0, (k == 7 || k == 9) ? "R4" : "R5");
                end
        // R6
        issue(4'd11, 1'b1, 1'b0, "R6");
        issue(4'd12, 1'b0, 1'b0, "R6");
        issue(4'd11, 1'b0, 1'b0, "R6");
        issue(4'd12, 1'b1, 1'b0, "R6");
        // R7
        issue(4'd13, 1'b1, 1'b0, "R7");
        issue(4'd13, 1'b0, 1'b0, "R7");
        issue(4'd14, 1'b0, 1'b0, "R7");
        issue(4'd14, 1'b1, 1'b0, "R7");
        // R8 test-and-clear, with and without guard (R9)
        issue(4'd2, 1'b0, 1'b0, "R2");
        issue(4'd15, 1'b1, 1'b0, "R8");
        issue(4'd15, 1'b0, 1'b0, "R8");
        issue(4'd15, 1'b1, 1'b1, "R9");
        issue(4'd15, 1'b0, 1'b1, "R9");
        // R9 guarded writes across bit ops
        issue(4'd5, 1'b0, 1'b1, "R9");
        issue(4'd6, 1'b1, 1'b1, "R9");
        issue(4'd12, 1'b0, 1'b1, "R9");
        issue(4'd11, 1'b0, 1'b1, "R9");
        issue(4'd13, 1'b1, 1'b1, "R9");
        // R10
        issue(4'd0, 1'b1, 1'b0, "R10");
        issue(4'd0, 1'b0, 1'b1, "R10");
        @(negedge clk);
        op = 4'd0;
        repeat (3) @(negedge clk);
        // R1 reset mid-run
        issue(4'd2, 1'b0, 1'b0, "R2");
        @(negedge clk);
        rst = 1'b1; op = 4'd5;
        @(negedge clk);
        checks++;
        if (cy !== 1'b0 || we !== 1'b0 || tk !== 1'b0) begin
            errors++;
            $display("FAIL R1: got cy=%b we=%b take=%b exp 0 0 0", cy, we, tk);
        end
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule